// File: doc/BRIEF.md
# Two-Wire Bus Master Free-Window and Arbitration Monitor

This block sits beside the master state machine of a two-wire serial controller. It watches the already synchronized data and clock lines. It decides when the master may issue a START or a repeated START. Once the master owns the bus, it detects when another master has taken the bus away.

While a start request is held, the block counts consecutive clocks in which both lines read high. It grants the start once that run reaches a programmed length. Any low sample restarts the run, so the block keeps retrying by itself until the grant is given. After the grant the block does no retrying; that is left to the controller.

During each clock-high phase, the block takes one sample of the data line at a fixed delay after the clock rises. It compares that sample with what the master meant to put on the line:

- A transmitted bit that does not match sets a sticky bus-loss flag and pulses an interrupt.
- An acknowledge seen in a slot where the master drives a not-acknowledge does the same.
- A slot in which the addressed target was required to answer but left the line high sets a sticky timeout flag.

Both flags stay set until the host clears them.

Top module: `i2c_arb_monitor`

## Requirements
- R1: After reset, start_grant_o, irq_o and both status_o bits are 0.
- R2: With start_req_i high, start_grant_o is a one-cycle pulse in the cycle after the N-th consecutive clock in which start_req_i, sda_i and scl_i are all high. N is free_cnt_i, and a value of 0 counts as 1, so it grants after the first high sample.
- R3: A clock with sda_i or scl_i low clears the run of high samples. After it, a grant needs a full fresh run of N samples.
- R4: With start_req_i low, no grant is given and the run is cleared. After a grant the run restarts from zero, so a request that stays high needs another full run before the next grant.
- R5: The data line is judged once per high phase of scl_i, in the (SAMPLE_DLY+1)-th consecutive high clock (SAMPLE_DLY defaults to 2). A high phase shorter than that is never judged, and inputs outside the judging clock have no effect on the status.
- R6: At a judging clock with tx_valid_i high and sda_i different from tx_bit_i, status_o[1] (bus loss) is 1 from the next cycle, and irq_o is high for exactly that one cycle.
- R7: At a judging clock with nack_slot_i high and sda_i low, status_o[1] sets and irq_o pulses as in R6. With sda_i high, neither happens.
- R8: At a judging clock with resp_slot_i high and sda_i high, status_o[0] (target timeout) is 1 from the next cycle. irq_o is not pulsed, and with sda_i low status_o[0] stays 0.
- R9: Both status bits stay set until clear_i is high for a clock, after which they read 0. If a bit is set by an event in the same clock as clear_i, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | Synchronized data line |
| scl_i | input | 1 | Synchronized clock line |
| free_cnt_i | input | CNT_W | Required run of high samples before a start |
| start_req_i | input | 1 | Master wants to issue START or repeated START |
| tx_valid_i | input | 1 | Current bit slot is driven by this master (address or write data) |
| tx_bit_i | input | 1 | Bit this master drives in the current slot |
| nack_slot_i | input | 1 | Current slot is a read acknowledge where this master drives not-acknowledge |
| resp_slot_i | input | 1 | Current slot requires the addressed target to pull the data line low |
| clear_i | input | 1 | Host clear of the sticky status bits |
| start_grant_o | output | 1 | One-cycle grant to issue the start |
| status_o | output | 2 | Bit 1 bus loss, bit 0 target timeout, both sticky |
| irq_o | output | 1 | One-cycle interrupt on each bus-loss event |

## Verification
The collision that matters is a host clear landing in the same clock as a new bus-loss event at a judging clock. The bench lines up clear_i with the (SAMPLE_DLY+1)-th high clock of a mismatching slot. It expects the bus-loss bit to remain set and the interrupt to pulse, while a timeout bit that was already set is cleared. Random runs with a sparse clear_i and frequent driven slots hit the same overlap many more times. A cycle model in the bench checks every one of them.

// File: rtl/arbmon_pkg.sv
package arbmon_pkg;
  localparam int unsigned ST_W       = 2;
  localparam int unsigned ST_TIMEOUT = 0;
  localparam int unsigned ST_BUSLOSS = 1;

  typedef struct packed {
    logic loss;
    logic timeout;
  } arb_evt_t;
endpackage

// File: rtl/arbmon_busfree.sv
module arbmon_busfree #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_i,
  input  logic             req_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             grant_o
);
  logic [CNT_W-1:0] run_q;
  logic [CNT_W:0]   run_incl;
  logic [CNT_W:0]   thr;
  logic             idle, hit, grant_q;

  assign idle     = sda_i & scl_i & req_i;
  assign run_incl = idle ? ({1'b0, run_q} + (CNT_W+1)'(1)) : '0;
  // zero limit behaves as one sample
  assign thr      = (limit_i == '0) ? (CNT_W+1)'(1) : {1'b0, limit_i};
  assign hit      = idle & (run_incl >= thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      grant_q <= 1'b0;
    end else begin
      run_q   <= hit ? '0 : run_incl[CNT_W-1:0];
      grant_q <= hit;
    end
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/arbmon_sampler.sv
module arbmon_sampler #(
  parameter int unsigned SAMPLE_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic sample_o
);
  localparam int unsigned HW = $clog2(SAMPLE_DLY + 2);
  localparam logic [HW-1:0] DLY = HW'(SAMPLE_DLY);
  localparam logic [HW-1:0] SAT = HW'(SAMPLE_DLY + 1);

  logic [HW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hi_q <= '0;
    else if (!scl_i)      hi_q <= '0;
    else if (hi_q != SAT) hi_q <= hi_q + HW'(1);
  end

  // saturation past DLY keeps it to one sample per phase
  assign sample_o = scl_i & (hi_q == DLY);
endmodule

// File: rtl/arbmon_judge.sv
module arbmon_judge
  import arbmon_pkg::*;
(
  input  logic     sample_i,
  input  logic     sda_i,
  input  logic     tx_valid_i,
  input  logic     tx_bit_i,
  input  logic     nack_slot_i,
  input  logic     resp_slot_i,
  output arb_evt_t evt_o
);
  logic tx_miss, ack_seen;

  assign tx_miss  = tx_valid_i & (sda_i ^ tx_bit_i);
  assign ack_seen = nack_slot_i & ~sda_i;

  always_comb begin
    evt_o.loss    = sample_i & (tx_miss | ack_seen);
    evt_o.timeout = sample_i & resp_slot_i & sda_i;
  end
endmodule

// File: rtl/arbmon_status.sv
module arbmon_status #(
  parameter int unsigned ST_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] set_i,
  input  logic            clear_i,
  output logic [ST_W-1:0] status_o
);
  logic [ST_W-1:0] st_q;

  for (genvar i = 0; i < ST_W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[i] <= 1'b0;
      else         st_q[i] <= set_i[i] | (st_q[i] & ~clear_i);
    end
  end

  assign status_o = st_q;
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
  import arbmon_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned SAMPLE_DLY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_i,
  input  logic [CNT_W-1:0] free_cnt_i,
  input  logic             start_req_i,
  input  logic             tx_valid_i,
  input  logic             tx_bit_i,
  input  logic             nack_slot_i,
  input  logic             resp_slot_i,
  input  logic             clear_i,
  output logic             start_grant_o,
  output logic [ST_W-1:0]  status_o,
  output logic             irq_o
);
  logic            sample;
  arb_evt_t        evt;
  logic [ST_W-1:0] set_vec;
  logic            irq_q;

  arbmon_busfree #(.CNT_W(CNT_W)) u_busfree (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sda_i   (sda_i),
    .scl_i   (scl_i),
    .req_i   (start_req_i),
    .limit_i (free_cnt_i),
    .grant_o (start_grant_o)
  );

  arbmon_sampler #(.SAMPLE_DLY(SAMPLE_DLY)) u_sampler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_i    (scl_i),
    .sample_o (sample)
  );

  arbmon_judge u_judge (
    .sample_i    (sample),
    .sda_i       (sda_i),
    .tx_valid_i  (tx_valid_i),
    .tx_bit_i    (tx_bit_i),
    .nack_slot_i (nack_slot_i),
    .resp_slot_i (resp_slot_i),
    .evt_o       (evt)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[ST_BUSLOSS] = evt.loss;
    set_vec[ST_TIMEOUT] = evt.timeout;
  end

  arbmon_status #(.ST_W(ST_W)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clear_i  (clear_i),
    .status_o (status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= evt.loss;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/arbmon_checker.sv
module arbmon_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_i,
  input logic       scl_i,
  input logic       start_req_i,
  input logic       resp_slot_i,
  input logic       clear_i,
  input logic       start_grant_o,
  input logic [1:0] status_o,
  input logic       irq_o
);
  a_r2_grant_needs_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_grant_o |-> $past(start_req_i && sda_i && scl_i));

  a_r3_low_blocks_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sda_i || !scl_i) |=> !start_grant_o);

  a_r4_no_req_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_req_i |=> !start_grant_o);

  a_r5_one_irq_per_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r6_irq_sets_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o[1]);

  a_r6_irq_needs_scl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(scl_i));

  a_r8_timeout_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> $past(resp_slot_i && sda_i && scl_i));

  a_r9_sticky_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] && !clear_i) |=> status_o[1]);

  a_r9_sticky_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !clear_i) |=> status_o[0]);
endmodule

bind i2c_arb_monitor arbmon_checker u_arbmon_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sda_i         (sda_i),
  .scl_i         (scl_i),
  .start_req_i   (start_req_i),
  .resp_slot_i   (resp_slot_i),
  .clear_i       (clear_i),
  .start_grant_o (start_grant_o),
  .status_o      (status_o),
  .irq_o         (irq_o)
);

// File: tb/test_i2c_arb_monitor.sv
module test_i2c_arb_monitor;
  localparam int DLY = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sda = 1'b1, scl = 1'b1, req = 1'b0;
  logic [15:0] ncnt = 16'd0;
  logic        txv = 1'b0, txb = 1'b0, nack = 1'b0, resp = 1'b0, clr = 1'b0;
  logic        start_grant_o, irq_o;
  logic [1:0]  status_o;

  int checks = 0, fails = 0, irq_seen = 0;
  string tag = "R1";

  int       m_run = 0, m_hi = 0;
  bit       m_grant = 0, m_irq = 0;
  bit [1:0] m_st = 0;

  always #2 clk = ~clk;

  i2c_arb_monitor #(.CNT_W(16), .SAMPLE_DLY(DLY)) i_i2c_arb_monitor (
    .clk_i (clk), .rst_ni (rst_ni), .sda_i (sda), .scl_i (scl),
    .free_cnt_i (ncnt), .start_req_i (req), .tx_valid_i (txv), .tx_bit_i (txb),
    .nack_slot_i (nack), .resp_slot_i (resp), .clear_i (clr),
    .start_grant_o (start_grant_o), .status_o (status_o), .irq_o (irq_o)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s]: actual %0d expected %0d", what, tag, act, exp);
    end
  endtask

  function automatic int thr_of(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic tick();
    int  run_incl;
    bit  both, g, sp, loss, to;
    both     = sda && scl;
    run_incl = (req && both) ? m_run + 1 : 0;
    g        = req && both && (run_incl >= thr_of(int'(ncnt)));
    sp       = scl && (m_hi == DLY);
    loss     = sp && ((txv && (sda != txb)) || (nack && !sda));
    to       = sp && resp && sda;
    @(posedge clk);
    @(negedge clk);
    m_run   = g ? 0 : run_incl;
    m_hi    = scl ? ((m_hi + 1 > DLY + 1) ? DLY + 1 : m_hi + 1) : 0;
    m_grant = g;
    m_st[1] = loss || (m_st[1] && !clr);
    m_st[0] = to || (m_st[0] && !clr);
    m_irq   = loss;
    if (irq_o) irq_seen++;
    chk(start_grant_o == m_grant, "R2 grant model", int'(start_grant_o), int'(m_grant));
    chk(status_o == m_st, "R9 status model", int'(status_o), int'(m_st));
    chk(irq_o == m_irq, "R6 irq model", int'(irq_o), int'(m_irq));
  endtask

  task automatic slot(input int hl, input bit s, input bit v, input bit b,
                      input bit n, input bit r);
    scl = 1'b0; tick(); tick();
    sda = s; txv = v; txb = b; nack = n; resp = r;
    scl = 1'b1;
    repeat (hl) tick();
    scl = 1'b0; txv = 1'b0; nack = 1'b0; resp = 1'b0;
    tick();
    sda = 1'b1;
  endtask

  task automatic do_clear();
    clr = 1'b1; tick(); clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog [%s]: actual 1 expected 0", tag);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c2b));
    repeat (3) @(negedge clk);
    tag = "R1";
    chk(start_grant_o == 1'b0 && irq_o == 1'b0 && status_o == 2'b00,
        "R1 outputs in reset", int'({start_grant_o, irq_o, status_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(status_o == 2'b00, "R1 status after reset", int'(status_o), 0);

    // R2 basic run
    tag = "R2"; ncnt = 16'd5; sda = 1; scl = 1; req = 1;
    repeat (4) tick();
    chk(start_grant_o == 0, "R2 no grant after 4 of 5", int'(start_grant_o), 0);
    tick();
    chk(start_grant_o == 1, "R2 grant after 5 of 5", int'(start_grant_o), 1);
    req = 0; tick();
    chk(start_grant_o == 0, "R2 grant is one pulse", int'(start_grant_o), 0);
    // zero count
    ncnt = 16'd0; req = 1; tick();
    chk(start_grant_o == 1, "R2 zero count grants at once", int'(start_grant_o), 1);
    req = 0; tick();
    scl = 0; req = 1; tick();
    chk(start_grant_o == 0, "R2 zero count needs high lines", int'(start_grant_o), 0);
    req = 0; scl = 1; tick();

    // R3 restart on low sample
    tag = "R3"; ncnt = 16'd4; req = 1;
    repeat (3) tick();
    sda = 0; tick(); sda = 1;
    repeat (3) tick();
    chk(start_grant_o == 0, "R3 run restarted after low", int'(start_grant_o), 0);
    tick();
    chk(start_grant_o == 1, "R3 grant after fresh run", int'(start_grant_o), 1);
    req = 0; tick();

    // R4 no request / restart after grant
    tag = "R4"; repeat (10) tick();
    chk(start_grant_o == 0, "R4 no grant without request", int'(start_grant_o), 0);
    ncnt = 16'd2; req = 1;
    repeat (2) tick();
    chk(start_grant_o == 1, "R4 first grant", int'(start_grant_o), 1);
    tick();
    chk(start_grant_o == 0, "R4 run restarts after grant", int'(start_grant_o), 0);
    tick();
    chk(start_grant_o == 1, "R4 second grant after new run", int'(start_grant_o), 1);
    req = 0; tick();

    // R5 short phase not judged
    tag = "R5"; irq_seen = 0;
    slot(DLY, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(status_o == 2'b00, "R5 short phase ignored", int'(status_o), 0);
    slot(DLY + 4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(status_o == 2'b00, "R5 matching bit no loss", int'(status_o), 0);

    // R6 mismatch
    tag = "R6";
    slot(DLY + 4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(status_o[1] == 1, "R6 loss on mismatch", int'(status_o[1]), 1);
    chk(irq_seen == 1, "R5 one irq per long phase", irq_seen, 1);
    do_clear();
    chk(status_o == 2'b00, "R9 clear", int'(status_o), 0);

    // R7 ack seen in nack slot
    tag = "R7";
    slot(DLY + 1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(status_o[1] == 0, "R7 nack honoured", int'(status_o[1]), 0);
    slot(DLY + 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(status_o[1] == 1, "R7 ack in nack slot", int'(status_o[1]), 1);
    do_clear();

    // R8 timeout
    tag = "R8"; irq_seen = 0;
    slot(DLY + 2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(status_o[0] == 0, "R8 target answered", int'(status_o[0]), 0);
    slot(DLY + 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(status_o == 2'b01, "R8 timeout set", int'(status_o), 1);
    chk(irq_seen == 0, "R8 no irq on timeout", irq_seen, 0);

    // R9 clear collides with new loss
    tag = "R9";
    scl = 0; tick(); tick();
    sda = 0; txv = 1; txb = 1; scl = 1;
    repeat (DLY) tick();
    clr = 1; tick(); clr = 0;
    chk(status_o == 2'b10, "R9 set wins over clear", int'(status_o), 2);
    chk(irq_o == 1, "R9 irq with collision", int'(irq_o), 1);
    scl = 0; txv = 0; tick(); sda = 1;
    repeat (5) tick();
    chk(status_o == 2'b10, "R9 sticky hold", int'(status_o), 2);
    do_clear();

    // random mix
    tag = "R2/R5/R6/R7/R8/R9 random";
    for (int i = 0; i < 4000; i++) begin
      sda  = ($urandom % 10) != 0;
      scl  = ($urandom % 4) != 0;
      req  = ($urandom % 3) != 0;
      ncnt = 16'($urandom % 7);
      txv  = ($urandom % 2) != 0;
      txb  = ($urandom % 2) != 0;
      nack = ($urandom % 4) == 0;
      resp = ($urandom % 4) == 0;
      clr  = ($urandom % 16) == 0;
      tick();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule